// File: doc/BRIEF.md
# Cell-averaging CFAR detector

This block decides, cell by cell, whether a range-Doppler map contains a target. It holds the map's magnitudes in an internal buffer that is loaded through a simple write port. When a scan begins, it visits every cell. For each cell under test it averages the reference cells along the range axis in the same Doppler column, scales that average by a programmable factor, and compares the cell against the scaled level.

Each cell takes a fixed three-phase sequence: sum, scale, test. The result strobe therefore arrives at a strict rate of one pulse every three clocks, and a downstream consumer may budget a three-cycle read-modify-write against it. Each pulse carries the cell's range and Doppler indices. At the default size the map is 64 range bins by 32 Doppler bins. Setting RANGE_BINS to 512 gives the full 16384-cell map of 17-bit magnitudes.

Top module: `cfar_ca_detector`

## Requirements
- R1: While reset is asserted and after it is released, with no start, det_valid, det_flag and done are all low.
- R2: A start sampled high while idle begins a scan. The first det_valid pulse is visible after the third rising edge that follows the edge that sampled start.
- R3: Every cell goes through the sum, scale and test phases in that order, one clock each. Consecutive det_valid pulses are exactly three clocks apart. A scan emits exactly RANGE_BINS*DOPPLER_BINS pulses, and det_valid is never high in two of any three consecutive cycles.
- R4: Cells are emitted with the Doppler index running fastest from 0 to DOPPLER_BINS-1, then the range index advances. det_range and det_doppler give the reported cell.
- R5: The reference set for cell (r,d) is the cells (r-GUARD-k,d) and (r+GUARD+k,d) for k=1..REF. Positions outside 0..RANGE_BINS-1 are dropped, and cnt is the number of cells kept.
- R6: det_flag is 1 exactly when 16*cnt*mag > alpha*sum, where sum is the total of the kept reference cells. This means alpha is unsigned with 4 fractional bits and the test is strict, so equality gives 0.
- R7: alpha is captured on the edge that starts a scan. Changes to alpha during the scan do not affect that scan's flags.
- R8: done goes low on the edge that starts a scan. It goes high on the edge that emits the last pulse and stays high, with no further pulses, until the next start.
- R9: A start that arrives while a scan is running is ignored. The pulse count and spacing of the running scan are unchanged.
- R10: A write with mag_wr_en high stores mag_wr_data at cell (mag_wr_range, mag_wr_doppler), which a later scan then uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan when idle |
| alpha | input | ALPHA_W | Threshold scale, 4 fractional bits |
| mag_wr_en | input | 1 | Magnitude write strobe |
| mag_wr_range | input | log2(RANGE_BINS) | Write cell range index |
| mag_wr_doppler | input | log2(DOPPLER_BINS) | Write cell Doppler index |
| mag_wr_data | input | MAG_W | Magnitude to store |
| det_valid | output | 1 | One-cycle result strobe |
| det_flag | output | 1 | Detection decision |
| det_range | output | log2(RANGE_BINS) | Range index of reported cell |
| det_doppler | output | log2(DOPPLER_BINS) | Doppler index of reported cell |
| done | output | 1 | Scan finished |

## Verification
A phase sequencer that skips or repeats a state shows up at once, on the next pulse, as a spacing other than three clocks or as a wrong index pair. A miscounted window at the map edges shows up only in the flags of the first and last GUARD+REF range rows, so those rows are filled with distinct values and each of their flags is compared against an independent model. A wrong alpha capture corrupts flags only after alpha changes in mid-scan, which is forced within ten clocks of a start.

// File: rtl/cfar_pkg.sv
package cfar_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SUM   = 2'd1,
    PH_SCALE = 2'd2,
    PH_TEST  = 2'd3
  } cfar_phase_e;

endpackage

// File: rtl/cfar_mag_buffer.sv
module cfar_mag_buffer #(
  parameter int RANGE_BINS   = 64,
  parameter int DOPPLER_BINS = 32,
  parameter int MAG_W        = 17,
  parameter int GUARD        = 2,
  parameter int REF          = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [$clog2(RANGE_BINS)-1:0]   wr_row,
  input  logic [$clog2(DOPPLER_BINS)-1:0] wr_col,
  input  logic [MAG_W-1:0]                wr_data,
  input  logic [$clog2(RANGE_BINS)-1:0]   rd_row,
  input  logic [$clog2(DOPPLER_BINS)-1:0] rd_col,
  output logic [MAG_W-1:0]                cut_mag,
  output logic [MAG_W+$clog2(2*REF+1)-1:0] win_sum,
  output logic [$clog2(2*REF+1)-1:0]      win_cnt
);
  localparam int RB    = $clog2(RANGE_BINS);
  localparam int DB    = $clog2(DOPPLER_BINS);
  localparam int CELLS = RANGE_BINS * DOPPLER_BINS;
  localparam int CNT_W = $clog2(2*REF+1);
  localparam int SUM_W = MAG_W + CNT_W;
  localparam int TAPS  = 2 * REF;

  logic [MAG_W-1:0] mem [CELLS];
  logic [MAG_W-1:0] tap_val [TAPS];
  logic [TAPS-1:0]  tap_ok;

  // Row-major storage: address = range * DOPPLER_BINS + doppler
  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_row, wr_col}] <= wr_data;
  end

  assign cut_mag = mem[{rd_row, rd_col}];

  // One lagging and one leading tap per reference distance
  for (genvar k = 0; k < REF; k++) begin : g_tap
    localparam int OFS = GUARD + 1 + k;
    logic          lo_ok, hi_ok;
    logic [RB-1:0] lo_row, hi_row;
    assign lo_ok  = (int'(rd_row) >= OFS);
    assign hi_ok  = (int'(rd_row) + OFS < RANGE_BINS);
    assign lo_row = RB'(int'(rd_row) - OFS);
    assign hi_row = RB'(int'(rd_row) + OFS);
    assign tap_ok[2*k]     = lo_ok;
    assign tap_ok[2*k+1]   = hi_ok;
    assign tap_val[2*k]    = lo_ok ? mem[{lo_row, rd_col}] : '0;
    assign tap_val[2*k+1]  = hi_ok ? mem[{hi_row, rd_col}] : '0;
  end

  always_comb begin
    win_sum = '0;
    for (int k = 0; k < TAPS; k++) win_sum = win_sum + SUM_W'(tap_val[k]);
  end

  assign win_cnt = CNT_W'($countones(tap_ok));

  // R5
  win_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_row) >= GUARD + REF && int'(rd_row) + GUARD + REF < RANGE_BINS)
      |-> win_cnt == CNT_W'(TAPS));

  // R5
  win_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (RANGE_BINS > GUARD + REF && rd_row == '0) |-> win_cnt == CNT_W'(REF));

endmodule

// File: rtl/cfar_scaler.sv
module cfar_scaler #(
  parameter int MAG_W      = 17,
  parameter int SUM_W      = 21,
  parameter int CNT_W      = 4,
  parameter int ALPHA_W    = 8,
  parameter int ALPHA_FRAC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_en,
  input  logic               scale_en,
  input  logic [SUM_W-1:0]   win_sum,
  input  logic [CNT_W-1:0]   win_cnt,
  input  logic [MAG_W-1:0]   cut_mag,
  input  logic [ALPHA_W-1:0] alpha,
  output logic               hit
);
  localparam int REF_W = SUM_W + ALPHA_W;
  localparam int CUT_W = MAG_W + CNT_W + ALPHA_FRAC;
  localparam int CW    = (REF_W > CUT_W) ? REF_W : CUT_W;

  // Scaled noise level: alpha * sum (alpha carries ALPHA_FRAC fraction bits)
  function automatic logic [CW-1:0] ref_level(input logic [ALPHA_W-1:0] a,
                                              input logic [SUM_W-1:0] s);
    return CW'(s) * CW'(a);
  endfunction

  // Cell brought to the same scale: mag * cnt * 2^ALPHA_FRAC
  function automatic logic [CW-1:0] cut_level(input logic [MAG_W-1:0] m,
                                              input logic [CNT_W-1:0] c);
    return (CW'(m) * CW'(c)) << ALPHA_FRAC;
  endfunction

  logic [SUM_W-1:0] sum_q;
  logic [CNT_W-1:0] cnt_q;
  logic [MAG_W-1:0] mag_q;
  logic [CW-1:0]    ref_q, cut_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      cnt_q <= '0;
      mag_q <= '0;
    end else if (cap_en) begin
      sum_q <= win_sum;
      cnt_q <= win_cnt;
      mag_q <= cut_mag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      cut_q <= '0;
    end else if (scale_en) begin
      ref_q <= ref_level(alpha, sum_q);
      cut_q <= cut_level(mag_q, cnt_q);
    end
  end

  assign hit = (cut_q > ref_q);

endmodule

// File: rtl/cfar_sequencer.sv
module cfar_sequencer #(
  parameter int RANGE_BINS   = 64,
  parameter int DOPPLER_BINS = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  output logic                            launch,
  output logic                            in_sum,
  output logic                            in_scale,
  output logic                            in_test,
  output logic                            is_idle,
  output logic [$clog2(RANGE_BINS)-1:0]   cut_range,
  output logic [$clog2(DOPPLER_BINS)-1:0] cut_doppler,
  output logic                            done
);
  import cfar_pkg::*;

  localparam int RB = $clog2(RANGE_BINS);
  localparam int DB = $clog2(DOPPLER_BINS);
  localparam logic [RB-1:0] LAST_R = RB'(RANGE_BINS - 1);
  localparam logic [DB-1:0] LAST_D = DB'(DOPPLER_BINS - 1);

  cfar_phase_e   phase_q;
  logic [RB-1:0] r_q;
  logic [DB-1:0] d_q;
  logic          done_q;
  logic          last_cell;

  assign last_cell = (r_q == LAST_R) && (d_q == LAST_D);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      r_q     <= '0;
      d_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_SUM;
          r_q     <= '0;
          d_q     <= '0;
          done_q  <= 1'b0;
        end
        PH_SUM:   phase_q <= PH_SCALE;
        PH_SCALE: phase_q <= PH_TEST;
        PH_TEST: begin
          if (last_cell) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            phase_q <= PH_SUM;
            if (d_q == LAST_D) begin
              d_q <= '0;
              r_q <= r_q + RB'(1);
            end else begin
              d_q <= d_q + DB'(1);
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign is_idle     = (phase_q == PH_IDLE);
  assign in_sum      = (phase_q == PH_SUM);
  assign in_scale    = (phase_q == PH_SCALE);
  assign in_test     = (phase_q == PH_TEST);
  assign launch      = is_idle && start;
  assign cut_range   = r_q;
  assign cut_doppler = d_q;
  assign done        = done_q;

  // R3
  sum_then_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_sum |=> in_scale);

  // R3
  scale_then_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_scale |=> in_test);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> is_idle);

  // R4
  doppler_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_test && cut_doppler != LAST_D)
      |=> (cut_doppler == $past(cut_doppler) + DB'(1)) && (cut_range == $past(cut_range)));

endmodule

// File: rtl/cfar_ca_detector.sv
module cfar_ca_detector #(
  parameter int RANGE_BINS   = 64,
  parameter int DOPPLER_BINS = 32,
  parameter int MAG_W        = 17,
  parameter int GUARD        = 2,
  parameter int REF          = 4,
  parameter int ALPHA_W      = 8,
  parameter int ALPHA_FRAC   = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [ALPHA_W-1:0]              alpha,
  input  logic                            mag_wr_en,
  input  logic [$clog2(RANGE_BINS)-1:0]   mag_wr_range,
  input  logic [$clog2(DOPPLER_BINS)-1:0] mag_wr_doppler,
  input  logic [MAG_W-1:0]                mag_wr_data,
  output logic                            det_valid,
  output logic                            det_flag,
  output logic [$clog2(RANGE_BINS)-1:0]   det_range,
  output logic [$clog2(DOPPLER_BINS)-1:0] det_doppler,
  output logic                            done
);
  localparam int RB    = $clog2(RANGE_BINS);
  localparam int DB    = $clog2(DOPPLER_BINS);
  localparam int CNT_W = $clog2(2*REF+1);
  localparam int SUM_W = MAG_W + CNT_W;

  logic               launch, in_sum, in_scale, in_test, is_idle;
  logic [RB-1:0]      cut_range;
  logic [DB-1:0]      cut_doppler;
  logic [MAG_W-1:0]   cut_mag;
  logic [SUM_W-1:0]   win_sum;
  logic [CNT_W-1:0]   win_cnt;
  logic [ALPHA_W-1:0] alpha_q;
  logic               hit;

  cfar_sequencer #(
    .RANGE_BINS   (RANGE_BINS),
    .DOPPLER_BINS (DOPPLER_BINS)
  ) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .launch      (launch),
    .in_sum      (in_sum),
    .in_scale    (in_scale),
    .in_test     (in_test),
    .is_idle     (is_idle),
    .cut_range   (cut_range),
    .cut_doppler (cut_doppler),
    .done        (done)
  );

  cfar_mag_buffer #(
    .RANGE_BINS   (RANGE_BINS),
    .DOPPLER_BINS (DOPPLER_BINS),
    .MAG_W        (MAG_W),
    .GUARD        (GUARD),
    .REF          (REF)
  ) i_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mag_wr_en),
    .wr_row  (mag_wr_range),
    .wr_col  (mag_wr_doppler),
    .wr_data (mag_wr_data),
    .rd_row  (cut_range),
    .rd_col  (cut_doppler),
    .cut_mag (cut_mag),
    .win_sum (win_sum),
    .win_cnt (win_cnt)
  );

  cfar_scaler #(
    .MAG_W      (MAG_W),
    .SUM_W      (SUM_W),
    .CNT_W      (CNT_W),
    .ALPHA_W    (ALPHA_W),
    .ALPHA_FRAC (ALPHA_FRAC)
  ) i_scale (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (in_sum),
    .scale_en (in_scale),
    .win_sum  (win_sum),
    .win_cnt  (win_cnt),
    .cut_mag  (cut_mag),
    .alpha    (alpha_q),
    .hit      (hit)
  );

  // Scale factor frozen for the whole scan
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      alpha_q <= '0;
    else if (launch) alpha_q <= alpha;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_valid   <= 1'b0;
      det_flag    <= 1'b0;
      det_range   <= '0;
      det_doppler <= '0;
    end else begin
      det_valid <= in_test;
      if (in_test) begin
        det_flag    <= hit;
        det_range   <= cut_range;
        det_doppler <= cut_doppler;
      end
    end
  end

  // R3
  pulse_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_valid |-> !$past(det_valid) && !$past(det_valid, 2));

  // R2
  pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_valid |-> $past(in_test));

  // R7
  alpha_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_idle && $past(!is_idle)) |-> $stable(alpha_q));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && in_scale) |=> in_test);

endmodule

// File: tb/test_cfar_ca_detector.sv
module test_cfar_ca_detector;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 16, ND = 4, MAG_W = 17, GUARD = 1, REF = 2, ALPHA_W = 8;
  localparam int RB = 4, DB = 2, NCELL = NR * ND;
  localparam int CR = 8, CD = 1;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [ALPHA_W-1:0] alpha = '0;
  logic               wr_en = 1'b0;
  logic [RB-1:0]      wr_r = '0;
  logic [DB-1:0]      wr_d = '0;
  logic [MAG_W-1:0]   wr_data = '0;
  logic               det_valid, det_flag, done;
  logic [RB-1:0]      det_range;
  logic [DB-1:0]      det_doppler;

  int checks = 0;
  int errors = 0;
  int mdl [NCELL];

  // {cut magnitude, flat level, alpha, expected flag} for cell (CR,CD)
  localparam int NVEC = 7;
  localparam logic [42:0] VEC [NVEC] = '{
    {17'd201,    17'd100,    8'd32,  1'b1},
    {17'd200,    17'd100,    8'd32,  1'b0},
    {17'd199,    17'd100,    8'd32,  1'b0},
    {17'd1,      17'd0,      8'd16,  1'b1},
    {17'd0,      17'd0,      8'd16,  1'b0},
    {17'd131071, 17'd131071, 8'd255, 1'b0},
    {17'd51,     17'd100,    8'd8,   1'b1}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  cfar_ca_detector #(
    .RANGE_BINS (NR), .DOPPLER_BINS (ND), .MAG_W (MAG_W),
    .GUARD (GUARD), .REF (REF), .ALPHA_W (ALPHA_W), .ALPHA_FRAC (4)
  ) i_cfar_ca_detector (
    .clk (clk), .rst_n (rst_n), .start (start), .alpha (alpha),
    .mag_wr_en (wr_en), .mag_wr_range (wr_r), .mag_wr_doppler (wr_d),
    .mag_wr_data (wr_data), .det_valid (det_valid), .det_flag (det_flag),
    .det_range (det_range), .det_doppler (det_doppler), .done (done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent statement of the window and decision rule
  function automatic bit model_hit(int r, int d, int a);
    longint s = 0;
    longint c = 0;
    for (int k = 1; k <= REF; k++) begin
      if (r - GUARD - k >= 0) begin s += mdl[(r-GUARD-k)*ND + d]; c++; end
      if (r + GUARD + k < NR) begin s += mdl[(r+GUARD+k)*ND + d]; c++; end
    end
    return (longint'(16) * c * longint'(mdl[r*ND + d])) > (longint'(a) * s);
  endfunction

  task automatic put(int r, int d, int v);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_r = RB'(r); wr_d = DB'(d); wr_data = MAG_W'(v);
    mdl[r*ND + d] = v;
  endtask

  task automatic end_writes();
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic fill_flat(int level, int cm);
    for (int r = 0; r < NR; r++)
      for (int d = 0; d < ND; d++)
        put(r, d, (r == CR && d == CD) ? cm : level);
    end_writes();
  endtask

  task automatic fill_ramp();
    for (int r = 0; r < NR; r++)
      for (int d = 0; d < ND; d++)
        put(r, d, ((r*7 + d*13) % 23) * 40 + ((r == 0 || r == NR-1) ? 600 : 0));
    end_writes();
  endtask

  task automatic run_pass(input int a0, input bit chg, input int a1, input bit restart,
                          input int cr, input int cd, input string tag, output int cut_flag);
    int n = 0;
    int cyc = 0;
    bit e;
    cut_flag = -1;
    @(posedge clk); #1;
    start = 1'b1; alpha = ALPHA_W'(a0);
    @(posedge clk); #1;
    start = 1'b0;
    while (cyc < NCELL*3 + 20) begin
      @(negedge clk);
      cyc++;
      if (cyc == 2) check(done == 1'b0, "R8 done cleared by start", done, 0);
      if (chg && cyc == 10) alpha = ALPHA_W'(a1);
      if (restart && cyc == 20) start = 1'b1;
      if (restart && cyc == 21) start = 1'b0;
      if (det_valid) begin
        check(cyc == 4 + 3*n, (n == 0) ? "R2 first pulse cycle" : "R3 pulse spacing", cyc, 4 + 3*n);
        check(int'(det_range) == n / ND && int'(det_doppler) == n % ND, "R4 cell order",
              int'(det_range)*ND + int'(det_doppler), n);
        e = model_hit(n / ND, n % ND, a0);
        check(det_flag == e, tag, det_flag, e);
        if (n / ND == cr && n % ND == cd) cut_flag = int'(det_flag);
        if (n == NCELL - 1) check(done == 1'b1, "R8 done with last pulse", done, 1);
        n++;
      end
      if (done) break;
    end
    check(n == NCELL, restart ? "R9 count with ignored start" : "R3 pulse count", n, NCELL);
    repeat (5) @(negedge clk);
    check(det_valid == 1'b0 && done == 1'b1, "R8 done holds without pulses",
          {det_valid, done}, 1);
  endtask

  initial begin
    int f;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(det_valid == 1'b0, "R1 det_valid in reset", det_valid, 0);
    check(det_flag == 1'b0, "R1 det_flag in reset", det_flag, 0);
    check(done == 1'b0, "R1 done in reset", done, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(det_valid == 1'b0 && done == 1'b0, "R1 quiet after reset", {det_valid, done}, 0);

    for (int i = 0; i < NVEC; i++) begin
      fill_flat(int'(VEC[i][25:9]), int'(VEC[i][42:26]));
      run_pass(int'(VEC[i][8:1]), 1'b0, 0, 1'b0, CR, CD, "R6 detection rule", f);
      check(f == int'(VEC[i][0]), "R6 table vector", f, VEC[i][0]);
    end

    fill_ramp();
    run_pass(24, 1'b0, 0, 1'b0, CR, CD, "R5 window clipping", f);

    run_pass(16, 1'b1, 255, 1'b0, CR, CD, "R7 alpha latched at start", f);

    run_pass(24, 1'b0, 0, 1'b1, CR, CD, "R9 flags with ignored start", f);

    put(8, 2, 100000);
    end_writes();
    run_pass(24, 1'b0, 0, 1'b0, 8, 2, "R10 written data used", f);
    check(f == 1, "R10 rewritten cell detected", f, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL R3 watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule